// File: doc/BRIEF.md
# Mode-Banked Status Word Unit

This block keeps the processor's live status word and a separate saved status word for each privileged exception mode. It carries out status-transfer operations issued by the pipeline. A read copies the live word or the saved word into a registered result port. A write replaces the target word in full, or replaces only its four condition flags. The write data comes either from a general register or from an immediate.

The mode that selects the saved bank and sets the privilege level is the mode field of the live word itself. Each request is gated by a condition-pass input. A request that breaks an access rule leaves all state unchanged and raises an illegal flag for one cycle. Two rules apply: user mode has no saved word, and register 15 may not be the register operand.

Word layout: flags N,Z,C,V in [31:28], two interrupt-disable bits in [7:6], mode in [4:0]. All other bits are stored as zero. Mode codes: user 5'b10000, fast interrupt 5'b10001, interrupt 5'b10010, supervisor 5'b10011, abort 5'b10111, undefined 5'b11011.

Top module: `psr_bank_unit`

## Requirements
- R1: After reset the live word is 32'h0000_00D3 (supervisor, both interrupt-disable bits set, flags clear), every saved word is zero, and `rd_vld_o` and `bad_o` are low.
- R2: When `cond_ok_i` is low, a request changes no stored word, and one cycle later `rd_vld_o` and `bad_o` are both low.
- R3: A legal read (`is_wr_i`=0) returns the live word (`use_saved_i`=0) or the saved word of the current mode (`use_saved_i`=1) on `rd_data_o`, with `rd_vld_o` high, in the cycle after the request.
- R4: A legal flags-only write (`full_i`=0) copies `wdata_i[31:28]` into bits [31:28] of the target word and leaves bits [27:0] unchanged.
- R5: In any mode other than user, a full write (`full_i`=1) replaces the target word with `wdata_i` AND 32'hF000_00DF.
- R6: In user mode, a write to the live word changes only bits [31:28], even when `full_i`=1.
- R7: Saved-word accesses reach only the bank of the mode held in the live word at the time of the request. Each of the five privileged modes has its own bank.
- R8: In user mode (or any mode code not listed), a saved-word access sets `bad_o` the next cycle and changes no stored word.
- R9: A request with `reg_idx_i`=15 sets `bad_o` the next cycle and changes no stored word. This applies to every read and to every write with `imm_i`=0. A write with `imm_i`=1 ignores `reg_idx_i`.
- R10: A write is committed at the clock edge that samples it, so a read issued in the next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cond_ok_i | input | 1 | Condition pass; a request takes effect only when high |
| is_wr_i | input | 1 | 1 = write, 0 = read |
| use_saved_i | input | 1 | 1 = saved word of current mode, 0 = live word |
| full_i | input | 1 | 1 = full write, 0 = flags-only write |
| imm_i | input | 1 | 1 = write data is an immediate (no register operand) |
| reg_idx_i | input | 4 | Destination register of a read, source register of a register write |
| wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read result, held until the next legal read |
| rd_vld_o | output | 1 | High for one cycle when `rd_data_o` carries a new result |
| bad_o | output | 1 | High for one cycle after an illegal request |

## Verification
All results are due exactly one rising edge after the request is sampled. `rd_vld_o`, `rd_data_o` and `bad_o` are registered there, and the stored words change at that same edge, so a read in the next cycle sees the write. The bench applies each request on a falling edge and updates its behavioural model at the same moment. On the following falling edge it compares the outputs with the model, one cycle later as the requirements require. Reads of every word after each write bring out the stored state, which also covers the cases where nothing may change.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int WORD_W   = 32;
  localparam int MODE_W   = 5;
  localparam int FLAG_W   = 4;
  localparam int N_BANKS  = 5;
  localparam int BANK_W   = $clog2(N_BANKS);

  localparam logic [MODE_W-1:0] M_USR = 5'b10000;
  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;

  // Bits that exist in a status word; all others are held at zero.
  localparam logic [WORD_W-1:0] LIVE_MASK  = 32'hF000_00DF;
  localparam logic [WORD_W-1:0] FLAG_MASK  = 32'hF000_0000;
  localparam logic [WORD_W-1:0] LIVE_RESET = 32'h0000_00D3;

  typedef struct packed {
    logic              has_bank;
    logic              priv;
    logic [BANK_W-1:0] idx;
  } mode_info_t;
endpackage

// File: rtl/psr_rst_sync.sv
module psr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/psr_mode_decode.sv
module psr_mode_decode
  import psr_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output mode_info_t        info_o
);
  always_comb begin
    info_o = '{has_bank: 1'b0, priv: 1'b1, idx: '0};
    unique case (mode_i)
      M_USR: info_o.priv = 1'b0;
      M_FIQ: begin info_o.has_bank = 1'b1; info_o.idx = BANK_W'(0); end
      M_IRQ: begin info_o.has_bank = 1'b1; info_o.idx = BANK_W'(1); end
      M_SVC: begin info_o.has_bank = 1'b1; info_o.idx = BANK_W'(2); end
      M_ABT: begin info_o.has_bank = 1'b1; info_o.idx = BANK_W'(3); end
      M_UND: begin info_o.has_bank = 1'b1; info_o.idx = BANK_W'(4); end
      default: ;
    endcase
  end
endmodule

// File: rtl/psr_word_merge.sv
module psr_word_merge
  import psr_pkg::*;
(
  input  logic [WORD_W-1:0] old_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              full_i,
  output logic [WORD_W-1:0] new_o
);
  always_comb begin
    if (full_i) new_o = wdata_i & LIVE_MASK;
    else        new_o = (old_i & ~FLAG_MASK) | (wdata_i & FLAG_MASK);
  end
endmodule

// File: rtl/psr_bank_unit.sv
module psr_bank_unit
  import psr_pkg::*;
#(
  parameter int REG_IDX_W = 4,
  parameter int PC_IDX    = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cond_ok_i,
  input  logic                 is_wr_i,
  input  logic                 use_saved_i,
  input  logic                 full_i,
  input  logic                 imm_i,
  input  logic [REG_IDX_W-1:0] reg_idx_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [WORD_W-1:0]    rd_data_o,
  output logic                 rd_vld_o,
  output logic                 bad_o
);
  localparam logic [REG_IDX_W-1:0] PC_CODE = REG_IDX_W'(PC_IDX);

  logic rst_q_n;
  psr_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  logic [WORD_W-1:0] live_q, live_d;
  logic [WORD_W-1:0] saved_q [N_BANKS];
  logic [WORD_W-1:0] saved_d;
  logic              live_en;
  logic [N_BANKS-1:0] saved_en;

  mode_info_t minfo;
  psr_mode_decode u_dec (.mode_i(live_q[MODE_W-1:0]), .info_o(minfo));

  logic [WORD_W-1:0] cur_saved;
  assign cur_saved = saved_q[minfo.idx];

  // Target word before the write, and its merged value.
  logic [WORD_W-1:0] tgt_old, tgt_new;
  logic              eff_full;
  assign tgt_old  = use_saved_i ? cur_saved : live_q;
  // User mode may only touch the flags of the live word.
  assign eff_full = full_i && (use_saved_i || minfo.priv);
  psr_word_merge u_merge (.old_i(tgt_old), .wdata_i(wdata_i),
                          .full_i(eff_full), .new_o(tgt_new));

  logic uses_reg, bad_reg, bad_bank, req_bad, req_ok;
  always_comb begin
    uses_reg = !(is_wr_i && imm_i);
    bad_reg  = uses_reg && (reg_idx_i == PC_CODE);
    bad_bank = use_saved_i && !minfo.has_bank;
    req_bad  = cond_ok_i && (bad_reg || bad_bank);
    req_ok   = cond_ok_i && !bad_reg && !bad_bank;
  end

  // Next-state for the stored words.
  always_comb begin
    live_en  = req_ok && is_wr_i && !use_saved_i;
    live_d   = tgt_new;
    saved_d  = tgt_new;
    saved_en = '0;
    if (req_ok && is_wr_i && use_saved_i) saved_en[minfo.idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     live_q <= LIVE_RESET;
    else if (live_en) live_q <= live_d;
  end

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n)         saved_q[b] <= '0;
      else if (saved_en[b]) saved_q[b] <= saved_d;
    end
  end

  // Result path.
  logic              rd_vld_d, bad_d, rd_en;
  logic [WORD_W-1:0] rd_data_d;
  always_comb begin
    rd_en     = req_ok && !is_wr_i;
    rd_vld_d  = rd_en;
    bad_d     = req_bad;
    rd_data_d = tgt_old;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rd_vld_o <= 1'b0;
      bad_o    <= 1'b0;
    end else begin
      rd_vld_o <= rd_vld_d;
      bad_o    <= bad_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)   rd_data_o <= '0;
    else if (rd_en) rd_data_o <= rd_data_d;
  end

  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    !cond_ok_i |=> (!rd_vld_o && !bad_o && $stable(live_q))); // R2
  AST_FLAGS_KEEP_CTRL: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cond_ok_i && is_wr_i && !use_saved_i && !full_i && !bad_reg)
      |=> (live_q[27:0] == $past(live_q[27:0]))); // R4
  AST_USER_CTRL_LOCK: assert property (@(posedge clk) disable iff (!rst_q_n)
    (live_q[MODE_W-1:0] == M_USR) |=> (live_q[27:0] == $past(live_q[27:0]))); // R6
  AST_USER_SAVED_BAD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cond_ok_i && use_saved_i && live_q[MODE_W-1:0] == M_USR) |=> (bad_o && !rd_vld_o)); // R8
  AST_PC_BAD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cond_ok_i && !is_wr_i && reg_idx_i == PC_CODE) |=> (bad_o && !rd_vld_o)); // R9
  AST_PC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cond_ok_i && is_wr_i && !imm_i && reg_idx_i == PC_CODE) |=> $stable(live_q)); // R9
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(rd_vld_o && bad_o)); // R3
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (live_q & ~LIVE_MASK) == '0); // R5
endmodule

// File: tb/sim_psr_bank_unit.sv
module sim_psr_bank_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cond_ok_i, is_wr_i, use_saved_i, full_i, imm_i;
  logic [3:0]  reg_idx_i;
  logic [31:0] wdata_i;
  logic [31:0] rd_data_o;
  logic        rd_vld_o, bad_o;

  always #2.5 clk = ~clk;

  psr_bank_unit u0 (.clk(clk), .rst_n(rst_n), .cond_ok_i(cond_ok_i), .is_wr_i(is_wr_i),
    .use_saved_i(use_saved_i), .full_i(full_i), .imm_i(imm_i), .reg_idx_i(reg_idx_i),
    .wdata_i(wdata_i), .rd_data_o(rd_data_o), .rd_vld_o(rd_vld_o), .bad_o(bad_o));

  int total = 0, bad = 0;
  bit done = 0;

  // Reference model state.
  int unsigned m_live;
  int unsigned m_saved [5];

  function automatic int bank_of(int unsigned mode);
    case (mode)
      5'h11: return 0; 5'h12: return 1; 5'h13: return 2;
      5'h17: return 3; 5'h1B: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_live = 32'hD3;
    foreach (m_saved[i]) m_saved[i] = 0;
  endtask

  task automatic do_reset();
    cond_ok_i = 0; is_wr_i = 0; use_saved_i = 0; full_i = 0; imm_i = 0;
    reg_idx_i = 0; wdata_i = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    model_reset();
  endtask

  // Apply one request on a falling edge; compare one cycle later.
  task automatic op(string req, bit c, bit w, bit s, bit f, bit im, int r, int unsigned d);
    int          bk;
    bit          e_bad, e_vld;
    int unsigned e_rd, old;
    cond_ok_i = c; is_wr_i = w; use_saved_i = s; full_i = f; imm_i = im;
    reg_idx_i = 4'(r); wdata_i = d;
    bk    = bank_of(m_live & 32'h1F);
    e_bad = c && (((r == 15) && !(w && im)) || (s && bk < 0));
    e_vld = c && !e_bad && !w;
    old   = s ? ((bk >= 0) ? m_saved[bk] : 0) : m_live;
    e_rd  = old;
    if (c && !e_bad && w) begin
      if (f && (s || bk >= 0 || (m_live & 32'h1F) != 5'h10))
        old = d & 32'hF00000DF;
      else
        old = (old & 32'h0FFFFFFF) | (d & 32'hF0000000);
      if (s) m_saved[bk] = old; else m_live = old;
    end
    @(negedge clk);
    chk({req, " valid"}, {31'b0, rd_vld_o}, {31'b0, e_vld});
    chk({req, " illegal"}, {31'b0, bad_o}, {31'b0, e_bad});
    if (e_vld) chk({req, " data"}, rd_data_o, e_rd);
  endtask

  task automatic rd_live(string req);  op(req, 1, 0, 0, 0, 0, 2, 0); endtask
  task automatic rd_saved(string req); op(req, 1, 0, 1, 0, 0, 2, 0); endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 valid", {31'b0, rd_vld_o}, 32'h0);
    chk("R1 illegal", {31'b0, bad_o}, 32'h0);
    rd_live("R1");
    chk("R1 live", rd_data_o, 32'hD3);
    rd_saved("R1");
    // R4 flags-only write to live word in supervisor
    op("R4", 1, 1, 0, 0, 1, 0, 32'hA5FF_FF00);
    rd_live("R4 R10");
    // R5 full write moves to fast interrupt, unused bits dropped
    op("R5", 1, 1, 0, 1, 0, 3, 32'h1234_5691);
    rd_live("R5");
    chk("R5 masked", rd_data_o, 32'h1000_0091);
    // R7 per-mode banks
    op("R7", 1, 1, 1, 1, 1, 0, 32'hFFFF_FFFF);
    rd_saved("R7 R10");
    op("R7", 1, 1, 0, 1, 1, 0, 32'h0000_00D2);
    rd_saved("R7 irq");
    chk("R7 irq bank empty", rd_data_o, 32'h0);
    op("R4", 1, 1, 1, 0, 0, 5, 32'h6000_0000);
    rd_saved("R4 saved");
    op("R7", 1, 1, 0, 1, 1, 0, 32'h0000_00D1);
    rd_saved("R7 fiq");
    chk("R7 fiq kept", rd_data_o, 32'hF000_00DF);
    // R2 condition false
    op("R2", 0, 1, 0, 1, 1, 0, 32'h0000_0010);
    op("R2", 0, 0, 0, 0, 0, 15, 0);
    rd_live("R2");
    // R9 register 15
    op("R9", 1, 0, 0, 0, 0, 15, 0);
    op("R9", 1, 1, 0, 1, 0, 15, 32'h0000_0010);
    op("R9 imm ok", 1, 1, 0, 0, 1, 15, 32'h3000_0000);
    rd_live("R9");
    // R6 user mode
    op("R6", 1, 1, 0, 1, 1, 0, 32'h0000_0010);
    op("R6", 1, 1, 0, 1, 1, 0, 32'hF000_00DF);
    rd_live("R6");
    chk("R6 ctrl locked", rd_data_o, 32'hF000_0010);
    // R8 saved access in user
    op("R8", 1, 0, 1, 0, 0, 2, 0);
    op("R8", 1, 1, 1, 1, 1, 0, 32'hFFFF_FFFF);
    op("R8", 1, 1, 1, 0, 0, 1, 32'hFFFF_FFFF);
    rd_live("R8");
    // Random phase against the model.
    do_reset();
    for (int i = 0; i < 400; i++) begin
      int unsigned d = $urandom;
      int unsigned modes [6] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B};
      if ((m_live & 32'h1F) == 5'h10 && $urandom_range(0, 7) == 0) begin
        do_reset();
        continue;
      end
      if ($urandom_range(0, 3) != 0)
        d = (d & 32'hFFFF_FFE0) | modes[$urandom_range(1, 5)];
      op("R3 R7 R10 rand", $urandom_range(0, 5) != 0, 1'($urandom), 1'($urandom),
         1'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0) ? 15 : $urandom_range(0, 14), d);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule